// File: doc/BRIEF.md
# Serial Block-Write Configuration Slave

This block is a two-wire serial slave that loads a small bank of 8-bit configuration registers, such as the output-enable bytes of a clock generator. It accepts one kind of transaction only: a block write. A master sends a start condition, the slave address byte, a command byte, a count byte and then the data bytes. The slave acknowledges every byte of a transfer addressed to it. It throws away the command and count values and writes the data bytes into the register bank one after another, always beginning at byte 0. There is no indexing, no read-back and no clock stretching.

Both bus lines are oversampled by the system clock through synchronizers. Start and stop conditions, and the SCL edges, are detected in the system clock domain. The slave drives the data line only through an active-high pull-down output, `sda_pull_o`. A transfer may stop after any complete data byte. Registers that the transfer did not reach keep their current values, and a byte cut short by a stop is discarded. The register bank has no stream interface: it is a set of plain level outputs that downstream logic decodes. In the default map, byte 1 holds eight SDRAM clock enables and byte 2 holds eight PCI clock enables, with bit n enabling output n (1 = enabled, 0 = held low).

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset the register bytes 0 to 6 read 06h, FFh, FFh, 8Ah, 02h, 00h, 06h, and `sda_pull_o` is 0.
- R2: An address byte of D2h (7-bit address 1101001 followed by write bit 0) is acknowledged: `sda_pull_o` is 1 while SCL is high during the ninth clock of the byte.
- R3: Any other address byte, including D3h (the read form), is not acknowledged. The slave then leaves SDA released and ignores the bus until the next start or stop, so no register changes.
- R4: The command byte and count byte that follow a matched address are acknowledged for any value, and they are never stored.
- R5: Data bytes are received most significant bit first and are stored in ascending order from byte 0. If the master stops after k complete data bytes, bytes k and up keep their previous values.
- R6: Data bytes beyond the last implemented register are acknowledged but discarded.
- R7: A repeated start, with no stop before it, begins a new transfer: the next byte is an address byte and data storage starts again at byte 0.
- R8: `sda_pull_o` changes only in the cycle after a detected falling SCL edge, start or stop. It is released after each acknowledge clock.
- R9: A stop that arrives in the middle of a byte discards the partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_o | output | NUM_REGS*8 | Register bank, byte k at bits [8k+7:8k] |

## Verification
The assertions assume a well-behaved bus master. SDA changes while SCL is high only to form a start or stop, and each SCL level lasts longer than the synchronizer latency, so edges and conditions are never detected in the wrong order. The stimulus keeps to these rules by driving every SCL phase and SDA setup for eight system clocks, and by changing SDA only while SCL is low except in the start and stop tasks. Under those conditions, the properties on when the pull-down may change and on when the register bank may move are well defined.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BITS,
    ST_HOLD,
    ST_ACK,
    ST_DROP
  } link_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } phase_e;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       return 8'h06;
      1, 2:    return 8'hFF;
      3:       return 8'h8A;
      4:       return 8'h02;
      6:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[SYNC_STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe[SYNC_STAGES-1];
  assign rise_o = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
  assign fall_o = ~pipe[SYNC_STAGES-1] & pipe[SYNC_STAGES];

endmodule

// File: rtl/cfgs_byte_engine.sv
module cfgs_byte_engine
  import cfgs_pkg::*;
#(
  parameter logic [7:0] SLAVE_BYTE = 8'hD2,
  parameter int         NUM_REGS   = 7,
  parameter int         IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_lvl_i,
  input  logic             sda_rise_i,
  input  logic             sda_fall_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             sda_pull_o,
  output logic             wr_valid_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);

  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_REGS);

  link_st_e       st;
  phase_e         phase;
  logic [2:0]     bit_cnt;
  logic [6:0]     shreg;
  logic [IDX_W:0] data_idx;
  logic [7:0]     full_byte;

  assign start_o   = sda_fall_i & scl_lvl_i;
  assign stop_o    = sda_rise_i & scl_lvl_i;
  assign full_byte = {shreg, sda_lvl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      phase      <= PH_ADDR;
      bit_cnt    <= '0;
      shreg      <= '0;
      data_idx   <= '0;
      sda_pull_o <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_valid_o <= 1'b0;
      if (stop_o) begin
        st         <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_o) begin
        st         <= ST_BITS;
        phase      <= PH_ADDR;
        bit_cnt    <= '0;
        data_idx   <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          ST_BITS: begin
            if (scl_rise_i) begin
              shreg   <= {shreg[5:0], sda_lvl_i};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                case (phase)
                  PH_ADDR: begin
                    if (full_byte == SLAVE_BYTE) begin
                      st    <= ST_HOLD;
                      phase <= PH_CMD;
                    end else begin
                      st <= ST_DROP;
                    end
                  end
                  PH_CMD: begin
                    st    <= ST_HOLD;
                    phase <= PH_CNT;
                  end
                  PH_CNT: begin
                    st    <= ST_HOLD;
                    phase <= PH_DATA;
                  end
                  default: begin
                    st <= ST_HOLD;
                    if (data_idx < LIMIT) begin
                      wr_valid_o <= 1'b1;
                      wr_idx_o   <= data_idx[IDX_W-1:0];
                      wr_data_o  <= full_byte;
                      data_idx   <= data_idx + 1'b1;
                    end
                  end
                endcase
              end
            end
          end
          ST_HOLD: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b1;
              st         <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              st         <= ST_BITS;
            end
          end
          default: begin
            sda_pull_o <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgs_reg_bank.sv
module cfgs_reg_bank
  import cfgs_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REGS*8-1:0] regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= reg_default(g);
      else if (wr_valid_i && (wr_idx_i == IDX_W'(g))) q <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = q;
  end

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int         NUM_REGS    = 7,
  parameter logic [7:0] SLAVE_BYTE  = 8'hD2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic wr_valid;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  cfgs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_scl_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (scl_i),
    .lvl_o  (scl_lvl),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  cfgs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sda_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (sda_i),
    .lvl_o  (sda_lvl),
    .rise_o (sda_rise),
    .fall_o (sda_fall)
  );

  cfgs_byte_engine #(
    .SLAVE_BYTE (SLAVE_BYTE),
    .NUM_REGS   (NUM_REGS),
    .IDX_W      (IDX_W)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl_i  (scl_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_lvl_i  (sda_lvl),
    .sda_rise_i (sda_rise),
    .sda_fall_i (sda_fall),
    .start_o    (start_det),
    .stop_o     (stop_det),
    .sda_pull_o (sda_pull_o),
    .wr_valid_o (wr_valid),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  cfgs_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .regs_o     (cfg_o)
  );

endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
  parameter int CFG_W = 56
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_pull,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             wr_valid,
  input logic [CFG_W-1:0] cfg
);

  // R8
  pull_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R8
  pull_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> $past(scl_fall || start_det || stop_det));

  // R7
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull);

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> $stable(cfg));

endmodule

bind cfg_serial_slave cfgs_checker #(.CFG_W(NUM_REGS*8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sda_pull  (sda_pull_o),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .wr_valid  (wr_valid),
  .cfg       (cfg_o)
);

// File: tb/test_cfg_serial_slave.sv
`timescale 1ns/1ps
module test_cfg_serial_slave;

  localparam int NREG = 7;
  localparam int H    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [NREG*8-1:0] cfg;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [7:0] exp_r [NREG];
  logic [7:0] frm [16];

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  cfg_serial_slave i_cfg_serial_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_pull_o (sda_pull),
    .cfg_o      (cfg)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(cfg[i*8 +: 8] == exp_r[i], req, {24'h0, cfg[i*8 +: 8]}, {24'h0, exp_r[i]});
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(H);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H);
    m_scl = 1'b1; wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b;    wt(H);
    m_scl = 1'b1; wt(H);
    m_scl = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wt(H);
    m_scl = 1'b1; wt(H/2);
    ack = ~sda_line;
    wt(H/2);
    m_scl = 1'b0; wt(H);
    // R8: pull-down released once the acknowledge clock has ended
    chk(sda_pull == 1'b0, "R8", {31'h0, sda_pull}, 32'h0);
  endtask

  // frm[0]=address, frm[1]=command, frm[2]=count, frm[3..]=data
  task automatic send_frame(input int nbytes, input bit do_stop);
    logic ack;
    bit   hit;
    hit = (frm[0] == 8'hD2);
    bus_start();
    for (int j = 0; j < nbytes; j++) begin
      send_byte(frm[j], ack);
      if (j == 0)      chk(ack == hit, hit ? "R2" : "R3", {31'h0, ack}, {31'h0, hit});
      else if (j < 3)  chk(ack == hit, hit ? "R4" : "R3", {31'h0, ack}, {31'h0, hit});
      else if (j < 3 + NREG) chk(ack == hit, hit ? "R5" : "R3", {31'h0, ack}, {31'h0, hit});
      else             chk(ack == hit, hit ? "R6" : "R3", {31'h0, ack}, {31'h0, hit});
      if (hit && j >= 3 && (j - 3) < NREG) exp_r[j-3] = frm[j];
    end
    if (do_stop) bus_stop();
  endtask

  initial begin
    logic ack;
    exp_r[0] = 8'h06; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF; exp_r[3] = 8'h8A;
    exp_r[4] = 8'h02; exp_r[5] = 8'h00; exp_r[6] = 8'h06;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R1: reset state
    check_regs("R1");
    chk(sda_pull == 1'b0, "R1", {31'h0, sda_pull}, 32'h0);

    // R2 R5: full write, count equals register count
    frm[0] = 8'hD2; frm[1] = 8'h00; frm[2] = 8'h07;
    for (int i = 0; i < NREG; i++) frm[3+i] = 8'(8'h11 * (i + 1));
    send_frame(3 + NREG, 1'b1);
    check_regs("R5");

    // R4 R5: walking-one sweep with arbitrary command and count values
    for (int k = 0; k < 8; k++) begin
      frm[0] = 8'hD2; frm[1] = 8'(k * 29 + 3); frm[2] = 8'(k);
      for (int i = 0; i < NREG; i++) frm[3+i] = 8'(1 << k) ^ 8'(i * 37);
      send_frame(3 + NREG, 1'b1);
      check_regs("R4");
    end

    // R5: stop after k data bytes leaves the rest untouched
    for (int n = 1; n < NREG; n++) begin
      frm[0] = 8'hD2; frm[1] = 8'h00; frm[2] = 8'(n);
      for (int i = 0; i < n; i++) frm[3+i] = 8'(8'hA5 + n * 13 + i * 7);
      send_frame(3 + n, 1'b1);
      check_regs("R5");
    end

    // R4: stop right after the count byte changes nothing
    frm[0] = 8'hD2; frm[1] = 8'hFF; frm[2] = 8'h20;
    send_frame(3, 1'b1);
    check_regs("R4");

    // R6: surplus data bytes acknowledged and dropped
    frm[0] = 8'hD2; frm[1] = 8'h00; frm[2] = 8'h0A;
    for (int i = 0; i < 10; i++) frm[3+i] = 8'(8'h3C + i * 19);
    send_frame(13, 1'b1);
    check_regs("R6");

    // R3: every single-bit corruption of the address byte is refused
    for (int b = 0; b < 8; b++) begin
      frm[0] = 8'hD2 ^ 8'(1 << b); frm[1] = 8'h00; frm[2] = 8'h03;
      frm[3] = 8'h00; frm[4] = 8'h5A; frm[5] = 8'hC3;
      send_frame(6, 1'b1);
      check_regs("R3");
    end

    // R7: repeated start restarts at byte 0
    frm[0] = 8'hD2; frm[1] = 8'h00; frm[2] = 8'h02; frm[3] = 8'h81; frm[4] = 8'h42;
    send_frame(5, 1'b0);
    frm[0] = 8'hD2; frm[1] = 8'h00; frm[2] = 8'h01; frm[3] = 8'h24;
    send_frame(4, 1'b1);
    check_regs("R7");
    chk(cfg[7:0] == 8'h24 && cfg[15:8] == 8'h42, "R7", {16'h0, cfg[15:0]}, 32'h4224);

    // R9: stop in the middle of a data byte discards it
    bus_start();
    send_byte(8'hD2, ack);
    chk(ack == 1'b1, "R9", {31'h0, ack}, 32'h1);
    send_byte(8'h00, ack);
    send_byte(8'h01, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    check_regs("R9");

    // R9: bus still usable after the aborted byte
    frm[0] = 8'hD2; frm[1] = 8'h00; frm[2] = 8'h01; frm[3] = 8'hE7;
    send_frame(4, 1'b1);
    check_regs("R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule